// File: doc/BRIEF.md
# Up/Down Timer with Set/Clear Control Ports

A single-channel timer/counter that advances once per prescaled count strobe (`tick`), counting up or down. Its control word is reached through two write ports. The set port turns on only the bits written as one. The clear port turns off only the bits written as one. Software therefore never needs a read-modify-write, and the live control word is always visible on `ctrl_rd`.

The control word carries a direction flag, a one-shot flag, an update-lock flag and a 3-bit command field. A command queued through the set port runs on the next `tick` and then reads back as zero. The active period and compare registers are each loaded from a buffer register. The copy happens at the wrap event, which is overflow when counting up and underflow when counting down. The lock flag can suppress that copy, except while input-capture mode (`cap_en`) is on. A wrap raises `wrap_o` for one cycle. With one-shot on, the counter stops after its first wrap.

Top module: `tc_setclr`

## Requirements
- R1: After reset, `ctrl_rd` is 0, `count` is 0, `running` is 1, `per_q` is all ones, `cmp_q` is 0 and `wrap_o` is 0.
- R2: Control word layout: bit 0 is one-shot, bit 1 is direction (1 = down), bit 2 is update-lock, and bits 5:3 are the command. A set-port write turns on each flag bit written as one and leaves flag bits written as zero unchanged. `ctrl_rd` shows the live value one cycle after the write.
- R3: A clear-port write turns off each flag bit written as one and leaves flag bits written as zero unchanged.
- R4: When both ports write the same bit in the same cycle, the set port wins.
- R5: A nonzero command written through the set port replaces the pending command, and zero has no effect. Any one in bits 5:3 of a clear-port write cancels the pending command. The command field reads back 0 after the next `tick`.
- R6: Command 1 (retrigger) loads `count` with 0 when counting up or with `per_q` when counting down, and starts the counter. Command 2 stops the counter with `count` held. Command 3 copies both buffers into the active registers regardless of the lock. Commands 4 to 7 leave the counter stepping normally.
- R7: On each `tick` while running, `count` increments when direction is 0 and decrements when direction is 1. Without `tick`, `count` holds.
- R8: Counting up with `count >= per_q`, a tick wraps `count` to 0. Counting down at 0, a tick wraps `count` to the period in effect before the wrap. `wrap_o` is high for exactly the cycle after that tick.
- R9: With one-shot set, a wrap clears `running`. The counter then holds until a retrigger command.
- R10: At a wrap, the period and compare buffers are copied into `per_q` and `cmp_q`, unless the lock is set while `cap_en` is 0.
- R11: Buffer writes do not change `per_q` or `cmp_q` until a copy occurs.
- R12: `cmp_hit` is high exactly when `count` equals `cmp_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count strobe |
| set_wr | input | 1 | Set-port write strobe |
| set_data | input | 6 | Set-port write data |
| clr_wr | input | 1 | Clear-port write strobe |
| clr_data | input | 6 | Clear-port write data |
| per_buf_wr | input | 1 | Period buffer write strobe |
| per_buf_data | input | W | Period buffer write data |
| cmp_buf_wr | input | 1 | Compare buffer write strobe |
| cmp_buf_data | input | W | Compare buffer write data |
| cap_en | input | 1 | Input-capture mode; overrides the update lock |
| ctrl_rd | output | 6 | Live control word, the same for both ports |
| count | output | W | Counter value |
| running | output | 1 | Counter is running |
| per_q | output | W | Active period |
| cmp_q | output | W | Active compare value |
| wrap_o | output | 1 | One-cycle wrap pulse |
| cmp_hit | output | 1 | Count equals compare |

## Verification
The counter is driven with sparse and back-to-back ticks, in both directions, with a direction change mid-count. This separates stepping on ticks from stepping on every clock, and shows each wrap target. Wraps are exercised with the lock clear, with the lock set, and with the lock set under capture mode, which tells a blocked copy apart from a taken one. Control writes cover lone set and clear writes, the same bit written through both ports at once, command cancel and reserved command codes. These show where the ports' priorities and the command field's self-clear differ.

// File: rtl/tc_setclr.sv
module tc_setclr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         set_wr,
  input  logic [5:0]   set_data,
  input  logic         clr_wr,
  input  logic [5:0]   clr_data,
  input  logic         per_buf_wr,
  input  logic [W-1:0] per_buf_data,
  input  logic         cmp_buf_wr,
  input  logic [W-1:0] cmp_buf_data,
  input  logic         cap_en,
  output logic [5:0]   ctrl_rd,
  output logic [W-1:0] count,
  output logic         running,
  output logic [W-1:0] per_q,
  output logic [W-1:0] cmp_q,
  output logic         wrap_o,
  output logic         cmp_hit
);
  localparam logic [2:0] CMD_RETRIG = 3'd1;
  localparam logic [2:0] CMD_STOP   = 3'd2;
  localparam logic [2:0] CMD_FUPD   = 3'd3;

  logic         oneshot, dir, lock;
  logic [2:0]   cmd, cmd_n;
  logic [W-1:0] per_buf, cmp_buf, cnt_n;
  logic         run_n, wrap_n, copy;

  assign ctrl_rd = {cmd, lock, dir, oneshot};
  assign cmp_hit = (count == cmp_q);

  always_comb begin
    cmd_n = tick ? 3'd0 : cmd;
    if (clr_wr && clr_data[5:3] != 3'd0) cmd_n = 3'd0;
    if (set_wr && set_data[5:3] != 3'd0) cmd_n = set_data[5:3];
  end

  always_comb begin
    cnt_n  = count;
    run_n  = running;
    wrap_n = 1'b0;
    copy   = 1'b0;
    if (tick) begin
      if (cmd == CMD_RETRIG) begin
        cnt_n = dir ? per_q : '0;
        run_n = 1'b1;
      end else if (cmd == CMD_STOP) begin
        run_n = 1'b0;
      end else if (running) begin
        if (!dir) begin
          if (count >= per_q) begin
            cnt_n  = '0;
            wrap_n = 1'b1;
          end else begin
            cnt_n = count + 1'b1;
          end
        end else begin
          if (count == '0) begin
            cnt_n  = per_q;
            wrap_n = 1'b1;
          end else begin
            cnt_n = count - 1'b1;
          end
        end
        if (wrap_n && oneshot) run_n = 1'b0;
      end
      copy = (cmd == CMD_FUPD) || (wrap_n && !(lock && !cap_en));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oneshot <= 1'b0;
      dir     <= 1'b0;
      lock    <= 1'b0;
      cmd     <= 3'd0;
      count   <= '0;
      running <= 1'b1;
      per_q   <= '1;
      cmp_q   <= '0;
      per_buf <= '1;
      cmp_buf <= '0;
      wrap_o  <= 1'b0;
    end else begin
      oneshot <= (set_wr & set_data[0]) | (oneshot & ~(clr_wr & clr_data[0]));
      dir     <= (set_wr & set_data[1]) | (dir & ~(clr_wr & clr_data[1]));
      lock    <= (set_wr & set_data[2]) | (lock & ~(clr_wr & clr_data[2]));
      cmd     <= cmd_n;
      count   <= cnt_n;
      running <= run_n;
      wrap_o  <= wrap_n;
      if (copy) begin
        per_q <= per_buf;
        cmp_q <= cmp_buf;
      end
      if (per_buf_wr) per_buf <= per_buf_data;
      if (cmp_buf_wr) cmp_buf <= cmp_buf_data;
    end
  end

  // R5
  cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(set_wr && set_data[5:3] != 3'd0)) |=> ctrl_rd[5:3] == 3'd0);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((ctrl_rd[2:0] & $past(set_data[2:0])) == $past(set_data[2:0])));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr) |=> ((ctrl_rd[2:0] & $past(clr_data[2:0])) == 3'd0));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(tick && ctrl_rd[5:3] == CMD_RETRIG)) |=> ($stable(count) && !running));

  // R10
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && ctrl_rd[5:3] == CMD_FUPD) && ctrl_rd[2] && !cap_en) |=> ($stable(per_q) && $stable(cmp_q)));

  // R8
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> $past(tick));
endmodule

// File: tb/tb_tc_setclr.sv
`timescale 1ns/1ps
module tb_tc_setclr;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, tick = 0, set_wr = 0, clr_wr = 0;
  logic [5:0] set_data = 0, clr_data = 0;
  logic per_buf_wr = 0, cmp_buf_wr = 0, cap_en = 0;
  logic [W-1:0] per_buf_data = 0, cmp_buf_data = 0;
  logic [5:0] ctrl_rd;
  logic [W-1:0] count, per_q, cmp_q;
  logic running, wrap_o, cmp_hit;

  tc_setclr #(.W(W)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cnt, m_per, m_cmp, m_pbuf, m_cbuf;
  bit m_run, m_wrap;
  bit [5:0] m_ctl;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_per = 65535; m_cmp = 0; m_pbuf = 65535; m_cbuf = 0;
    m_run = 1; m_wrap = 0; m_ctl = 0;
  endtask

  task automatic model_step();
    bit [2:0] c = m_ctl[5:3];
    bit os = m_ctl[0], dn = m_ctl[1], lk = m_ctl[2];
    bit ev = 0, cp = 0, nr = m_run;
    int nc = m_cnt;
    bit [5:0] nctl = m_ctl;
    if (tick) begin
      if (c == 1) begin nc = dn ? m_per : 0; nr = 1; end
      else if (c == 2) nr = 0;
      else if (m_run) begin
        if (!dn) begin
          if (m_cnt >= m_per) begin nc = 0; ev = 1; end else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nc = m_per; ev = 1; end else nc = m_cnt - 1;
        end
        if (ev && os) nr = 0;
      end
      cp = (c == 3) || (ev && !(lk && !cap_en));
      nctl[5:3] = 0;
    end
    if (cp) begin m_per = m_pbuf; m_cmp = m_cbuf; end
    if (per_buf_wr) m_pbuf = per_buf_data;
    if (cmp_buf_wr) m_cbuf = cmp_buf_data;
    if (clr_wr) begin
      nctl[2:0] = nctl[2:0] & ~clr_data[2:0];
      if (clr_data[5:3] != 0) nctl[5:3] = 0;
    end
    if (set_wr) begin
      nctl[2:0] = nctl[2:0] | set_data[2:0];
      if (set_data[5:3] != 0) nctl[5:3] = set_data[5:3];
    end
    m_cnt = nc; m_run = nr; m_wrap = ev; m_ctl = nctl;
  endtask

  task automatic compare();
    chk(ctrl_rd == m_ctl, "R2 ctrl_rd", ctrl_rd, m_ctl);
    chk(count == m_cnt, "R7 count", count, m_cnt);
    chk(running == m_run, "R9 running", running, m_run);
    chk(wrap_o == m_wrap, "R8 wrap_o", wrap_o, m_wrap);
    chk(per_q == m_per, "R10 per_q", per_q, m_per);
    chk(cmp_q == m_cmp, "R10 cmp_q", cmp_q, m_cmp);
    chk(cmp_hit == (m_cnt == m_cmp), "R12 cmp_hit", cmp_hit, m_cnt == m_cmp);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    tick = 0; set_wr = 0; clr_wr = 0; per_buf_wr = 0; cmp_buf_wr = 0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; step();
      for (int j = 0; j < gap; j++) step();
    end
  endtask

  task automatic wset(input bit [5:0] d, input bit t);
    set_wr = 1; set_data = d; tick = t; step();
  endtask

  task automatic wclr(input bit [5:0] d, input bit t);
    clr_wr = 1; clr_data = d; tick = t; step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();
    chk(ctrl_rd == 0 && count == 0 && running == 1, "R1 reset state", ctrl_rd, 0);
    chk(per_q == 16'hFFFF && cmp_q == 0 && wrap_o == 0, "R1 reset regs", per_q, 65535);

    wset(6'b000_101, 0);
    chk(ctrl_rd == 6'b000_101, "R2 set flags", ctrl_rd, 5);
    wclr(6'b000_001, 0);
    chk(ctrl_rd == 6'b000_100, "R3 clear one flag", ctrl_rd, 4);
    set_wr = 1; set_data = 6'b000_100; clr_wr = 1; clr_data = 6'b000_110; step();
    chk(ctrl_rd[2] == 1, "R4 set wins lock", ctrl_rd[2], 1);
    wclr(6'b000_100, 0);

    per_buf_wr = 1; per_buf_data = 5; cmp_buf_wr = 1; cmp_buf_data = 3; step();
    chk(per_q == 16'hFFFF && cmp_q == 0, "R11 buffer not active", per_q, 65535);
    wset(6'b011_000, 0);
    chk(ctrl_rd[5:3] == 3, "R5 command pending", ctrl_rd[5:3], 3);
    step();
    chk(ctrl_rd[5:3] == 3, "R5 waits for tick", ctrl_rd[5:3], 3);
    ticks(1, 0);
    chk(per_q == 5 && cmp_q == 3 && ctrl_rd[5:3] == 0, "R6 force update", per_q, 5);

    wset(6'b001_000, 1);
    ticks(1, 0);
    chk(count == 0 && running, "R6 retrigger up", count, 0);
    ticks(8, 2);
    ticks(6, 0);

    wset(6'b000_010, 0);
    ticks(9, 1);
    chk(ctrl_rd[1] == 1, "R7 down mode", ctrl_rd[1], 1);
    wclr(6'b000_010, 0);
    ticks(3, 0);

    per_buf_wr = 1; per_buf_data = 7; step();
    wset(6'b000_100, 0);
    ticks(8, 0);
    chk(per_q == 5, "R10 lock blocks copy", per_q, 5);
    cap_en = 1;
    ticks(8, 0);
    chk(per_q == 7, "R10 capture overrides lock", per_q, 7);
    cap_en = 0;
    wclr(6'b000_100, 0);

    wset(6'b010_000, 0);
    wclr(6'b100_000, 0);
    chk(ctrl_rd[5:3] == 0, "R5 clear cancels", ctrl_rd[5:3], 0);
    ticks(2, 0);
    chk(running == 1, "R5 canceled stop ignored", running, 1);
    wset(6'b000_000, 0);
    wset(6'b101_000, 0);
    ticks(2, 0);
    chk(running == 1, "R6 reserved code", running, 1);

    wset(6'b000_001, 0);
    ticks(12, 0);
    chk(running == 0, "R9 one-shot stopped", running, 0);
    ticks(4, 1);
    wset(6'b001_000, 0);
    ticks(3, 0);
    chk(running == 1, "R9 resumed by retrigger", running, 1);
    wset(6'b010_000, 0);
    ticks(2, 0);
    chk(running == 0, "R6 stop command", running, 0);
    wclr(6'b000_001, 0);
    set_wr = 1; set_data = 6'b001_010; step();
    ticks(4, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule